// File: doc/BRIEF.md
# Parking Bus Arbiter with Overlapped Selection

This block decides which of several masters owns a shared synchronous bus. Each master has its own request line and its own grant line, so every request is seen at once. Exactly one grant is high at all times. When nobody else wants the bus, the grant stays with the last owner. That owner can then start another transfer without waiting for arbitration.

The owner holds `busy_i` high for as long as it uses the bus. While the owner is busy, a selection stage registers the next candidate. It searches the requesters with a rotating priority that starts one past the current owner. When the owner drops `busy_i`, the grant moves at that same clock edge, so no idle cycle is spent on arbitration. A master must not drive the bus unless its grant is high. The request and grant lines are plain level signals with no valid/ready handshake. No data passes through the block.

Top module: `bus_park_arbiter`

## Requirements
- R1: While reset (`rst_n` low) is applied, and after it is released, the grant is parked on master 0: `gnt_o` = bit 0 only and `owner_o` = 0.
- R2: Exactly one bit of `gnt_o` is high in every cycle, and `owner_o` is the index of that bit.
- R3: At a clock edge where `busy_i` is high, the grant does not change, whatever the requests are.
- R4: At a clock edge where no master other than the owner requests, the grant does not change. The bus stays parked on the previous owner even if its own request is low.
- R5: A request is registered as the next candidate at the first edge that sees it. The grant moves to that candidate at the first later edge where `busy_i` is low. From an idle parked state this is the second edge after the request appears. For a request held during a busy transfer, it is the very edge at which `busy_i` is first sampled low.
- R6: The candidate is the first requesting master found by searching upward in index from one past the current owner and wrapping from N_MASTERS-1 to 0. The owner itself is considered last.
- R7: The grant moves only to a master whose request is high at the edge of the move. A candidate that has withdrawn its request is not granted, and the grant stays where it was.
- R8: When all masters request continuously and each owner releases after a busy transfer, ownership visits every master within N_MASTERS handovers, in ascending index order with wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_MASTERS | One request line per master |
| busy_i | input | 1 | High while the current owner is using the bus; low means released |
| gnt_o | output | N_MASTERS | One-hot grant, one line per master |
| owner_o | output | $clog2(N_MASTERS) | Index of the granted master |

## Verification
The bench checks the exact edge at which the grant moves. If the design arbitrated only after the release instead of during the transfer, the grant would land one cycle late after a busy period. If it ignored the registered candidate stage, the grant would land one cycle early from idle. The bench also checks the rotation start point and its wrap: a pointer that restarted at master 0 or skipped one index would hand the bus to the wrong master, and under full load one master would be starved. Parking and withdrawn candidates are observed at `gnt_o`. A design that dropped the grant when requests vanished, or granted a master whose request had gone, shows a wrong owner there.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Action taken by the ownership register at a clock edge.
  typedef enum logic {
    ARB_HOLD   = 1'b0,
    ARB_SWITCH = 1'b1
  } arb_act_e;

endpackage

// File: rtl/arb_rr_pick.sv
// Rotating search: the first set request at or above ptr, wrapping to 0.
module arb_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          vld,
  output logic [IW-1:0] idx
);

  always_comb begin
    logic [IW:0] pos;
    vld = 1'b0;
    idx = ptr;
    pos = '0;
    for (int k = 0; k < N; k++) begin
      pos = {1'b0, ptr} + (IW+1)'(k);
      if (pos >= (IW+1)'(N)) pos = pos - (IW+1)'(N);
      if (!vld && req[pos[IW-1:0]]) begin
        vld = 1'b1;
        idx = pos[IW-1:0];
      end
    end
  end

endmodule

// File: rtl/arb_cand_stage.sv
// Registers the selected next owner every cycle, so selection overlaps the
// current owner's transfer.
module arb_cand_stage #(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pick_vld,
  input  logic [IW-1:0] pick_idx,
  output logic          cand_vld,
  output logic [IW-1:0] cand_idx
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_vld <= 1'b0;
      cand_idx <= '0;
    end else begin
      cand_vld <= pick_vld;
      cand_idx <= pick_idx;
    end
  end

endmodule

// File: rtl/arb_owner_ctrl.sv
// Ownership register and rotating pointer; ownership passes only on release.
module arb_owner_ctrl
  import arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          busy,
  input  logic          cand_vld,
  input  logic [IW-1:0] cand_idx,
  output logic [IW-1:0] owner,
  output logic [IW-1:0] ptr
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  arb_act_e      act;
  logic [IW-1:0] after_cand;

  always_comb begin
    act = ARB_HOLD;
    if (!busy && cand_vld && req[cand_idx] && (cand_idx != owner))
      act = ARB_SWITCH;
    after_cand = (cand_idx == LAST) ? '0 : cand_idx + IW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner <= '0;
      ptr   <= IW'(1);
    end else if (act == ARB_SWITCH) begin
      owner <= cand_idx;
      ptr   <= after_cand;
    end
  end

endmodule

// File: rtl/bus_park_arbiter.sv
module bus_park_arbiter #(
  parameter  int N_MASTERS = 4,
  localparam int IDX_W     = $clog2(N_MASTERS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic                 busy_i,
  output logic [N_MASTERS-1:0] gnt_o,
  output logic [IDX_W-1:0]     owner_o
);

  logic             pick_vld;
  logic [IDX_W-1:0] pick_idx;
  logic             cand_vld;
  logic [IDX_W-1:0] cand_idx;
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] owner;

  arb_rr_pick #(.N(N_MASTERS), .IW(IDX_W)) u_pick (
    .req (req_i),
    .ptr (ptr),
    .vld (pick_vld),
    .idx (pick_idx)
  );

  arb_cand_stage #(.IW(IDX_W)) u_cand (
    .clk      (clk),
    .rst_n    (rst_n),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx),
    .cand_vld (cand_vld),
    .cand_idx (cand_idx)
  );

  arb_owner_ctrl #(.N(N_MASTERS), .IW(IDX_W)) u_own (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_i),
    .busy     (busy_i),
    .cand_vld (cand_vld),
    .cand_idx (cand_idx),
    .owner    (owner),
    .ptr      (ptr)
  );

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_gnt
    assign gnt_o[g] = (owner == IDX_W'(g));
  end

  assign owner_o = owner;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req,
  input logic          busy,
  input logic [N-1:0]  gnt,
  input logic [IW-1:0] owner
);

  // R2
  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt) == 1);

  // R3
  a_r3_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(gnt));

  // R4
  a_r4_park_no_rival: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & ~gnt) == '0) |=> $stable(gnt));

  // R7
  a_r7_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gnt) |-> ((gnt & $past(req)) != '0));

  // R2: owner index and grant line move together
  a_r2_owner_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(owner) |-> !$stable(gnt));

endmodule

bind bus_park_arbiter arb_checker #(.N(N_MASTERS), .IW(IDX_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (req_i),
  .busy  (busy_i),
  .gnt   (gnt_o),
  .owner (owner_o)
);

// File: tb/bus_park_arbiter_test.sv
module bus_park_arbiter_test;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req_i;
  logic          busy_i;
  logic [N-1:0]  gnt_o;
  logic [IW-1:0] owner_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_park_arbiter #(.N_MASTERS(N)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .busy_i  (busy_i),
    .gnt_o   (gnt_o),
    .owner_o (owner_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_owner(input int exp, input string tag);
    logic [N-1:0] eg;
    eg = N'(1) << exp;
    n_checks++;
    if (gnt_o !== eg || owner_o !== IW'(exp) || $countones(gnt_o) != 1) begin
      n_fail++;
      $display("FAIL %s: gnt=%b owner=%0d expected gnt=%b owner=%0d",
               tag, gnt_o, owner_o, eg, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_i = '0; busy_i = 1'b0;
    step(2);
    expect_owner(0, "R1 during reset");
    rst_n = 1'b1;
    step(1);
    expect_owner(0, "R1 after reset");
  endtask

  task automatic t_park;
    req_i = 4'b0001; step(4);
    expect_owner(0, "R4 owner alone requesting");
    req_i = '0; step(4);
    expect_owner(0, "R4 no requests keeps park");
  endtask

  task automatic t_idle_handover;
    req_i = 4'b0100; step(1);
    expect_owner(0, "R5 candidate edge no move yet");
    step(1);
    expect_owner(2, "R5 second edge moves grant");
    req_i = '0; step(3);
    expect_owner(2, "R4 parked on new owner");
  endtask

  task automatic t_busy_overlap;
    busy_i = 1'b1; req_i = 4'b0110; step(4);
    expect_owner(2, "R3 busy holds grant");
    busy_i = 1'b0; step(1);
    expect_owner(1, "R5 move at first released edge");
    busy_i = 1'b1; req_i = '0; step(2);
    expect_owner(1, "R3 busy new owner");
  endtask

  task automatic t_rotation;
    req_i = 4'b1001; step(3);
    busy_i = 1'b0; step(1);
    expect_owner(3, "R6 search from one past owner");
    busy_i = 1'b1; step(2);
    busy_i = 1'b0; step(1);
    expect_owner(0, "R6 wrap to master 0");
    req_i = '0; step(1);
  endtask

  task automatic t_withdraw;
    busy_i = 1'b1; req_i = 4'b0010; step(3);
    req_i = '0; busy_i = 1'b0; step(2);
    expect_owner(0, "R7 withdrawn candidate not granted");
  endtask

  task automatic t_starvation;
    bit [N-1:0] seen;
    int prev;
    seen = '0;
    prev = 0;
    req_i = '1;
    for (int i = 0; i < 2*N; i++) begin
      busy_i = 1'b1; step(2);
      busy_i = 1'b0; step(1);
      prev = (prev + 1) % N;
      expect_owner(prev, "R8 ascending handover under full load");
      seen[prev] = 1'b1;
      if (i == N-1) begin
        n_checks++;
        if (seen != '1) begin
          n_fail++;
          $display("FAIL R8: visited=%b expected=%b", seen, {N{1'b1}});
        end
      end
    end
    busy_i = 1'b1; req_i = '0; step(1);
    busy_i = 1'b0; step(1);
  endtask

  initial begin
    t_reset();
    t_park();
    t_idle_handover();
    t_busy_overlap();
    t_rotation();
    t_withdraw();
    t_starvation();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule